// File: doc/BRIEF.md
# Standby and Wake Controller

This block decides when a small controller core may sleep and when it must wake. A one-cycle sleep request from the core either gates only the CPU clock (light sleep) or also shuts the oscillator (deep sleep). A mode input selects between the two. Deep sleep is never entered while the interval timer is still counting. The CPU halts at once, the oscillator keeps running until the count ends, and only then is it switched off.

Release comes from one selected source: the serial input pin, any key I/O pin, any key input pin, or the serial-shift setting, which always releases. Each pin source has a programmable active level. Timer completion can be enabled as an extra release source. A request that arrives while a release condition already holds is dropped, and the core keeps running.

Two protection checks turn illegal sleep states into a one-cycle system reset request:
- a hang-up detector that looks at the key I/O state when deep sleep is entered;
- a configuration check that rejects sleeping on a pin source strapped as unused.

After a deep-sleep wake the oscillator restarts immediately. The CPU clock returns only after a fixed settle count.

The states are RUN, LIGHT (ST_HALT), STOP_WAIT, DEEP (ST_STOP), SETTLE and RESET. The transitions are:
- RUN to LIGHT, STOP_WAIT, DEEP or RESET on a sleep request.
- LIGHT to RUN on release.
- STOP_WAIT to RUN on release, or to DEEP or RESET when the timer goes idle.
- DEEP to SETTLE on release.
- SETTLE to RUN after the settle count.
- RESET to RUN after one cycle.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, cpu_clk_en=1, osc_en=1 and sys_reset_req=0.
- R2: With stop_mode=0, a sleep request (with no release condition true) clears cpu_clk_en on the next cycle while osc_en stays 1. On release, cpu_clk_en returns one cycle after the release is seen, with no settle delay.
- R3: With stop_mode=1 and timer_busy=0, a sleep request clears both osc_en and cpu_clk_en on the next cycle.
- R4: With stop_mode=1 and timer_busy=1, a sleep request clears cpu_clk_en but osc_en stays 1. osc_en falls on the cycle after timer_busy drops.
- R5: On release from deep sleep, osc_en rises at once. cpu_clk_en stays 0 for exactly SETTLE_CYCLES (16) cycles and then returns to 1.
- R6: wake_src selects the pin source: 0 = serial pin, 1 = key I/O (any pin at the level), 2 = key input (any pin at the level). wake_level=1 releases on a high level and wake_level=0 on a low level.
- R7: wake_src=3 (serial shift) always counts as released, so a sleep request is dropped.
- R8: With timer_wake_en=1, the timer being idle (timer_busy=0) releases standby.
- R9: A sleep request while a release condition already holds is ignored: cpu_clk_en and osc_en stay 1 and no reset is raised.
- R10: With hang_det_en=1, entering deep sleep while kio_out_mode=0 or any key I/O pin is 0 raises sys_reset_req for one cycle instead of stopping the oscillator.
- R11: A sleep request with wake_src=0 while sin_unused=1, or with wake_src=1 while kio_unused=1, raises sys_reset_req for one cycle.
- R12: Pin inputs pass through two flops. A pin change applied after a clock edge releases standby at the third edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | One-cycle sleep request from the core |
| stop_mode | input | 1 | 0 = light sleep, 1 = deep sleep (oscillator off) |
| timer_busy | input | 1 | Interval timer is counting |
| wake_src | input | 2 | Release source select (see R6, R7) |
| wake_level | input | 1 | Active level of the selected pin source |
| timer_wake_en | input | 1 | Timer completion also releases |
| hang_det_en | input | 1 | Hang-up detector enable |
| sin_unused | input | 1 | Strap: serial pin is not used for release |
| kio_unused | input | 1 | Strap: key I/O is not used for release |
| kio_out_mode | input | 1 | Key I/O direction, 1 = output |
| sin_pin | input | 1 | Serial input pin |
| kio_pins | input | KIO_W | Key I/O pin levels |
| ki_pins | input | KI_W | Key input pin levels |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_reset_req | output | 1 | One-cycle full system reset request |

## Verification
The bench builds the block with its defaults: eight key I/O pins, four key input pins, two synchroniser stages and a settle count of 16. With these values the exact cycle of each release can be predicted: three edges after a pin change, and sixteen cycles of settle after a deep wake. Both boundaries are checked on the cycle before and the cycle of the change. Eight key I/O pins let a single low bit among otherwise high pins exercise both the "any pin" release and the hang-up detector.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_HALT      = 3'd1,
        ST_STOP_WAIT = 3'd2,
        ST_STOP      = 3'd3,
        ST_SETTLE    = 3'd4,
        ST_RESET     = 3'd5
    } stby_state_e;

    typedef enum logic [1:0] {
        SRC_SER_PIN   = 2'd0,
        SRC_KEY_IO    = 2'd1,
        SRC_KEY_IN    = 2'd2,
        SRC_SER_SHIFT = 2'd3
    } wake_src_e;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stby_wake_eval.sv
module stby_wake_eval
    import standby_pkg::*;
#(
    parameter int KIO_W = 8,
    parameter int KI_W  = 4
) (
    input  wake_src_e         src,
    input  logic              level,
    input  logic              sin_s,
    input  logic [KIO_W-1:0]  kio_s,
    input  logic [KI_W-1:0]   ki_s,
    input  logic              timer_wake_en,
    input  logic              timer_busy,
    input  logic              hang_det_en,
    input  logic              kio_out_mode,
    input  logic              sin_unused,
    input  logic              kio_unused,
    output logic              wake_now,
    output logic              cfg_fault,
    output logic              hang_fault
);
    logic pin_hit;

    always_comb begin
        pin_hit = 1'b0;
        unique case (src)
            SRC_SER_PIN:   pin_hit = (sin_s == level);
            SRC_KEY_IO:    pin_hit = level ? (|kio_s) : ~(&kio_s);
            SRC_KEY_IN:    pin_hit = level ? (|ki_s)  : ~(&ki_s);
            SRC_SER_SHIFT: pin_hit = 1'b1;
            default:       pin_hit = 1'b0;
        endcase
    end

    assign wake_now   = pin_hit | (timer_wake_en & ~timer_busy);
    assign cfg_fault  = ((src == SRC_SER_PIN) & sin_unused) |
                        ((src == SRC_KEY_IO)  & kio_unused);
    assign hang_fault = hang_det_en & (~kio_out_mode | ~(&kio_s));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import standby_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic stop_mode,
    input  logic timer_busy,
    input  logic wake_now,
    input  logic cfg_fault,
    input  logic hang_fault,
    output logic cpu_clk_en,
    output logic osc_en,
    output logic sys_reset_req
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    stby_state_e     state, nxt;
    logic [CNT_W-1:0] cnt;

    // state register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_SETTLE) ? cnt + 1'b1 : '0;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (halt_req && !wake_now) begin
                    if (cfg_fault)       nxt = ST_RESET;
                    else if (!stop_mode) nxt = ST_HALT;
                    else if (timer_busy) nxt = ST_STOP_WAIT;
                    else if (hang_fault) nxt = ST_RESET;
                    else                 nxt = ST_STOP;
                end
            end
            ST_HALT: begin
                if (wake_now) nxt = ST_RUN;
            end
            ST_STOP_WAIT: begin
                if (wake_now)         nxt = ST_RUN;
                else if (!timer_busy) nxt = hang_fault ? ST_RESET : ST_STOP;
            end
            ST_STOP: begin
                if (wake_now) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt == CNT_LAST) nxt = ST_RUN;
            end
            ST_RESET: nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        cpu_clk_en    = 1'b0;
        osc_en        = 1'b1;
        sys_reset_req = 1'b0;
        unique case (state)
            ST_RUN:       cpu_clk_en = 1'b1;
            ST_HALT:      cpu_clk_en = 1'b0;
            ST_STOP_WAIT: cpu_clk_en = 1'b0;
            ST_STOP:      osc_en     = 1'b0;
            ST_SETTLE:    cpu_clk_en = 1'b0;
            ST_RESET: begin
                cpu_clk_en    = 1'b0;
                sys_reset_req = 1'b1;
            end
            default:      cpu_clk_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int KIO_W         = 8,
    parameter int KI_W          = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             stop_mode,
    input  logic             timer_busy,
    input  logic [1:0]       wake_src,
    input  logic             wake_level,
    input  logic             timer_wake_en,
    input  logic             hang_det_en,
    input  logic             sin_unused,
    input  logic             kio_unused,
    input  logic             kio_out_mode,
    input  logic             sin_pin,
    input  logic [KIO_W-1:0] kio_pins,
    input  logic [KI_W-1:0]  ki_pins,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             sys_reset_req
);
    localparam int PIN_W = 1 + KIO_W + KI_W;

    logic [PIN_W-1:0] pins_s;
    logic             sin_s;
    logic [KIO_W-1:0] kio_s;
    logic [KI_W-1:0]  ki_s;
    logic             wake_now, cfg_fault, hang_fault;

    stby_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sin_pin, kio_pins, ki_pins}),
        .q     (pins_s)
    );

    assign {sin_s, kio_s, ki_s} = pins_s;

    stby_wake_eval #(.KIO_W(KIO_W), .KI_W(KI_W)) u_eval (
        .src           (wake_src_e'(wake_src)),
        .level         (wake_level),
        .sin_s         (sin_s),
        .kio_s         (kio_s),
        .ki_s          (ki_s),
        .timer_wake_en (timer_wake_en),
        .timer_busy    (timer_busy),
        .hang_det_en   (hang_det_en),
        .kio_out_mode  (kio_out_mode),
        .sin_unused    (sin_unused),
        .kio_unused    (kio_unused),
        .wake_now      (wake_now),
        .cfg_fault     (cfg_fault),
        .hang_fault    (hang_fault)
    );

    stby_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_req      (halt_req),
        .stop_mode     (stop_mode),
        .timer_busy    (timer_busy),
        .wake_now      (wake_now),
        .cfg_fault     (cfg_fault),
        .hang_fault    (hang_fault),
        .cpu_clk_en    (cpu_clk_en),
        .osc_en        (osc_en),
        .sys_reset_req (sys_reset_req)
    );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk #(
    parameter int SETTLE = 16
) (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic timer_busy,
    input logic wake_now,
    input logic cpu_clk_en,
    input logic osc_en,
    input logic sys_reset_req
);
    logic osc_q;
    logic from_stop;
    int   settle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q      <= 1'b1;
            from_stop  <= 1'b0;
            settle_cnt <= 0;
        end else begin
            osc_q <= osc_en;
            if (osc_en && !osc_q) begin
                from_stop  <= 1'b1;
                settle_cnt <= 1;
            end else if (from_stop && !cpu_clk_en) begin
                settle_cnt <= settle_cnt + 1;
            end else if (cpu_clk_en) begin
                from_stop <= 1'b0;
            end
        end
    end

    // R3
    osc_off_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);

    // R4
    busy_keeps_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && timer_busy) |=> osc_en);

    // R4
    osc_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(!timer_busy));

    // R5
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (from_stop && $rose(cpu_clk_en)) |-> (settle_cnt == SETTLE));

    // R9
    ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_req && wake_now) |=> (cpu_clk_en && osc_en));

    // R10
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);
endmodule

bind standby_ctrl standby_ctrl_chk #(.SETTLE(SETTLE_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_req      (halt_req),
    .timer_busy    (timer_busy),
    .wake_now      (wake_now),
    .cpu_clk_en    (cpu_clk_en),
    .osc_en        (osc_en),
    .sys_reset_req (sys_reset_req)
);

// File: tb/test_standby_ctrl.sv
module test_standby_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, stop_mode = 1'b0, timer_busy = 1'b0;
    logic [1:0] wake_src = 2'd0;
    logic       wake_level = 1'b1, timer_wake_en = 1'b0, hang_det_en = 1'b0;
    logic       sin_unused = 1'b0, kio_unused = 1'b0, kio_out_mode = 1'b1;
    logic       sin_pin = 1'b0;
    logic [7:0] kio_pins = 8'hFF;
    logic [3:0] ki_pins = 4'h0;
    logic       cpu_clk_en, osc_en, sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    standby_ctrl i_standby_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_mode(stop_mode),
        .timer_busy(timer_busy), .wake_src(wake_src), .wake_level(wake_level),
        .timer_wake_en(timer_wake_en), .hang_det_en(hang_det_en),
        .sin_unused(sin_unused), .kio_unused(kio_unused),
        .kio_out_mode(kio_out_mode), .sin_pin(sin_pin), .kio_pins(kio_pins),
        .ki_pins(ki_pins), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sleep_req();
        @(negedge clk) halt_req = 1'b1;
        @(negedge clk) halt_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", cpu_clk_en, 1'b1, "cpu_clk_en after reset");
        chk("R1", osc_en, 1'b1, "osc_en after reset");
        chk("R1", sys_reset_req, 1'b0, "sys_reset_req after reset");
    endtask

    task automatic t_light_sleep();
        stop_mode = 1'b0; wake_src = 2'd0; wake_level = 1'b1; sin_pin = 1'b0;
        wait_n(4);
        sleep_req();
        chk("R2", cpu_clk_en, 1'b0, "light sleep cpu");
        chk("R2", osc_en, 1'b1, "light sleep osc");
        sin_pin = 1'b1;
        wait_n(2);
        chk("R12", cpu_clk_en, 1'b0, "still asleep after two edges");
        wait_n(1);
        chk("R2", cpu_clk_en, 1'b1, "cpu back at third edge");
        sin_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_deep_sleep();
        stop_mode = 1'b1; wake_src = 2'd0; wake_level = 1'b1; sin_pin = 1'b0;
        sleep_req();
        chk("R3", osc_en, 1'b0, "deep sleep osc");
        chk("R3", cpu_clk_en, 1'b0, "deep sleep cpu");
        sin_pin = 1'b1;
        wait_n(3);
        chk("R5", osc_en, 1'b1, "osc restarts on wake");
        chk("R5", cpu_clk_en, 1'b0, "cpu held at settle start");
        wait_n(15);
        chk("R5", cpu_clk_en, 1'b0, "cpu held on last settle cycle");
        wait_n(1);
        chk("R5", cpu_clk_en, 1'b1, "cpu back after 16 cycles");
        sin_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_deep_busy();
        stop_mode = 1'b1; timer_wake_en = 1'b0; timer_busy = 1'b1;
        sleep_req();
        chk("R4", cpu_clk_en, 1'b0, "cpu stops while timer busy");
        chk("R4", osc_en, 1'b1, "osc kept while timer busy");
        wait_n(5);
        chk("R4", osc_en, 1'b1, "osc still kept");
        timer_busy = 1'b0;
        wait_n(1);
        chk("R4", osc_en, 1'b0, "osc off after timer idle");
        sin_pin = 1'b1;
        wait_n(22);
        chk("R5", cpu_clk_en, 1'b1, "running after wake");
        sin_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_timer_wake();
        stop_mode = 1'b0; timer_wake_en = 1'b1; timer_busy = 1'b1;
        sleep_req();
        chk("R8", cpu_clk_en, 1'b0, "asleep while timer busy");
        timer_busy = 1'b0;
        wait_n(1);
        chk("R8", cpu_clk_en, 1'b1, "timer idle releases");
        timer_wake_en = 1'b0;
        wait_n(2);
    endtask

    task automatic t_key_io_low();
        stop_mode = 1'b0; wake_src = 2'd1; wake_level = 1'b0; kio_pins = 8'hFF;
        wait_n(4);
        sleep_req();
        wait_n(5);
        chk("R6", cpu_clk_en, 1'b0, "no key I/O pin low");
        kio_pins = 8'hFE;
        wait_n(3);
        chk("R6", cpu_clk_en, 1'b1, "key I/O low releases");
        kio_pins = 8'hFF;
        wait_n(4);
    endtask

    task automatic t_key_in_high();
        stop_mode = 1'b0; wake_src = 2'd2; wake_level = 1'b1; ki_pins = 4'h0;
        wait_n(4);
        sleep_req();
        wait_n(4);
        chk("R6", cpu_clk_en, 1'b0, "no key input high");
        ki_pins = 4'h4;
        wait_n(3);
        chk("R6", cpu_clk_en, 1'b1, "key input high releases");
        ki_pins = 4'h0;
        wait_n(4);
    endtask

    task automatic t_shift_src();
        stop_mode = 1'b1; wake_src = 2'd3;
        sleep_req();
        chk("R7", cpu_clk_en, 1'b1, "shift source drops request");
        chk("R7", osc_en, 1'b1, "shift source keeps osc");
    endtask

    task automatic t_ignore();
        wake_src = 2'd0; wake_level = 1'b1; sin_pin = 1'b1; stop_mode = 1'b1;
        wait_n(4);
        sleep_req();
        chk("R9", cpu_clk_en, 1'b1, "request ignored cpu");
        chk("R9", osc_en, 1'b1, "request ignored osc");
        chk("R9", sys_reset_req, 1'b0, "request ignored reset");
        sin_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_hang();
        hang_det_en = 1'b1; stop_mode = 1'b1; wake_src = 2'd0; wake_level = 1'b1;
        kio_out_mode = 1'b0; kio_pins = 8'hFF;
        sleep_req();
        chk("R10", sys_reset_req, 1'b1, "input mode hang reset");
        wait_n(1);
        chk("R10", sys_reset_req, 1'b0, "reset is one cycle");
        chk("R10", cpu_clk_en, 1'b1, "running after reset");
        kio_out_mode = 1'b1;
        sleep_req();
        chk("R10", osc_en, 1'b0, "legal deep sleep stops osc");
        chk("R10", sys_reset_req, 1'b0, "legal deep sleep no reset");
        sin_pin = 1'b1;
        wait_n(22);
        sin_pin = 1'b0;
        kio_pins = 8'hF7;
        wait_n(4);
        sleep_req();
        chk("R10", sys_reset_req, 1'b1, "low key I/O pin hang reset");
        chk("R10", osc_en, 1'b1, "osc kept on hang reset");
        kio_pins = 8'hFF; hang_det_en = 1'b0;
        wait_n(4);
    endtask

    task automatic t_unused();
        stop_mode = 1'b0; wake_src = 2'd0; sin_unused = 1'b1; sin_pin = 1'b0;
        sleep_req();
        chk("R11", sys_reset_req, 1'b1, "unused serial source reset");
        wait_n(1);
        sin_unused = 1'b0;
        wake_src = 2'd1; wake_level = 1'b0; kio_unused = 1'b1;
        sleep_req();
        chk("R11", sys_reset_req, 1'b1, "unused key I/O source reset");
        wait_n(1);
        chk("R11", cpu_clk_en, 1'b1, "running after reset");
        kio_unused = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_light_sleep();
        t_deep_sleep();
        t_deep_busy();
        t_timer_wake();
        t_key_io_low();
        t_key_in_high();
        t_shift_src();
        t_ignore();
        t_hang();
        t_unused();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule